// File: doc/BRIEF.md
# Cascadable Eight-Input Interrupt Controller

This block collects eight level-sensitive interrupt request lines. It picks the most urgent one that is neither masked nor blocked by work already in service, and raises an interrupt line toward the processor. When the processor acknowledges, the controller records the chosen request as in service. One cycle later it presents an 8-bit vector made from a programmable base and the request index. The in-service bit stays set until software writes an end-of-interrupt command.

A strap input selects the master role or the slave role. In a cascaded system, each slave's interrupt output feeds one request input of the master. The master marks that input as cascaded. When the cascaded input wins, the master publishes its index on a 3-bit cascade bus during the acknowledge and stays off the data bus. The slave whose programmed identity matches the bus supplies the vector instead. One master and eight slaves reach 64 sources.

The processor side is synchronous to the block clock. The chip-select, read and write strobes and a register-select bit are sampled on the rising edge. Bidirectional pins are split into data and enable pairs, and the pad ring turns them into tri-state drivers.

Top module: `pic_cascade`

## Requirements
- R1: After reset the mask register reads 8'hFF, the in-service register reads 8'h00, the base and cascade configuration are zero, int_o is low, and neither data_oe_o nor cas_oe_o is asserted.
- R2: int_o is high whenever at least one eligible request exists. Among eligible requests, index 0 has the highest priority and index 7 the lowest.
- R3: A request whose mask bit is 1 never raises int_o and never wins.
- R4: While in-service bit k is set, requests with index k or higher are not eligible. Requests with index below k remain eligible.
- R5: A one-cycle acknowledge pulse on inta_i while a request wins has these effects:
  - The winner's in-service bit is set at that clock edge.
  - In the next cycle only, data_oe_o is high and data_o carries {base[4:0], index[2:0]}.
  - This holds unless the winner is cascaded on a master, or the device is a slave that is not selected.
- R6: A command-port write (a0_i=0) with data bits [7:6]=2'b00 clears the lowest-indexed set in-service bit.
- R7: A command-port write with bits [7:6]=2'b01 clears the in-service bit whose index is in data bits [2:0].
- R8: A command-port write with bits [7:6]=2'b10 loads data bits [4:0] into the vector base.
- R9: A command-port write with bits [7:6]=2'b11 arms configuration. The next a0_i=1 write then goes to the configuration register instead of the mask, and the mask is left unchanged. On a master the configuration bit i marks input i as cascaded. On a slave, configuration bits [2:0] hold its identity. Any other a0_i=1 write loads the mask.
- R10: On a master (sp_i=1), if the winning input is cascaded, then during inta_i cas_oe_o is high and cas_o equals the winning index. No vector is driven in the following cycle.
- R11: A slave (sp_i=0) acts on inta_i only when cas_i equals its identity. Otherwise its in-service register stays unchanged and it drives no vector.
- R12: With cs_i and rd_i high, data_oe_o is high and data_o returns the in-service register for a0_i=0 or the mask for a0_i=1.
- R13: Writes with cs_i low change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sp_i | input | 1 | Role strap: 1 master, 0 slave |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| a0_i | input | 1 | Register select |
| data_i | input | 8 | Write data from processor |
| data_o | output | 8 | Read data or vector |
| data_oe_o | output | 1 | Data bus drive enable |
| ir_i | input | 8 | Request lines, index 0 most urgent |
| int_o | output | 1 | Interrupt to processor or to master |
| inta_i | input | 1 | Acknowledge pulse |
| cas_i | input | 3 | Cascade bus input (slave) |
| cas_o | output | 3 | Cascade bus output (master) |
| cas_oe_o | output | 1 | Cascade bus drive enable |

## Verification
The bench builds two copies with the default eight inputs and 8-bit data: a master strapped high and a slave strapped low. The slave's int_o drives master input 3, and the master's cas_o feeds the slave's cas_i. This pairing makes the cascaded hand-off reachable:
- the master steps off the bus and the matching slave answers, and
- a non-matching cascade code leaves the slave silent.

Random masks and request patterns on the master cover the priority choice. Directed nesting sequences cover in-service blocking and both end-of-interrupt forms.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    OP_EOI_ANY = 2'b00,
    OP_EOI_LVL = 2'b01,
    OP_BASE    = 2'b10,
    OP_CFG     = 2'b11
  } pic_op_e;
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int N_IR   = 8,
  parameter int DATA_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic                     a0_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [N_IR-1:0]          imr_o,
  output logic [DATA_W-$clog2(N_IR)-1:0] base_o,
  output logic [N_IR-1:0]          cfg_o,
  output logic                     eoi_any_o,
  output logic                     eoi_lvl_o,
  output logic [$clog2(N_IR)-1:0]  eoi_idx_o
);
  localparam int IDX_W  = $clog2(N_IR);
  localparam int BASE_W = DATA_W - IDX_W;

  pic_op_e op;
  logic    cfg_arm_q;
  logic    cmd_wr;

  assign op        = pic_op_e'(wdata_i[DATA_W-1 -: 2]);
  assign cmd_wr    = wr_en_i && !a0_i;
  assign eoi_any_o = cmd_wr && (op == OP_EOI_ANY);
  assign eoi_lvl_o = cmd_wr && (op == OP_EOI_LVL);
  assign eoi_idx_o = wdata_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      imr_o     <= '1;
      base_o    <= '0;
      cfg_o     <= '0;
      cfg_arm_q <= 1'b0;
    end else if (wr_en_i) begin
      if (a0_i) begin
        if (cfg_arm_q) begin
          cfg_o     <= wdata_i[N_IR-1:0];
          cfg_arm_q <= 1'b0;
        end else begin
          imr_o <= wdata_i[N_IR-1:0];
        end
      end else begin
        case (op)
          OP_BASE: base_o    <= wdata_i[BASE_W-1:0];
          OP_CFG:  cfg_arm_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assert_no_write_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(imr_o) && $stable(base_o) && $stable(cfg_o));
  assert_cfg_keeps_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && a0_i && cfg_arm_q) |=> $stable(imr_o));
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N_IR = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_IR-1:0]         ir_i,
  input  logic [N_IR-1:0]         imr_i,
  input  logic [N_IR-1:0]         isr_i,
  output logic                    win_vld_o,
  output logic [$clog2(N_IR)-1:0] win_idx_o
);
  localparam int IDX_W = $clog2(N_IR);

  logic [N_IR-1:0] isr_pref;
  logic [N_IR-1:0] cand;

  // isr_pref[i]: some request of index <= i is in service
  for (genvar i = 0; i < N_IR; i++) begin : g_pref
    if (i == 0) begin : g_first
      assign isr_pref[i] = isr_i[i];
    end else begin : g_rest
      assign isr_pref[i] = isr_pref[i-1] | isr_i[i];
    end
    assign cand[i] = ir_i[i] & ~imr_i[i] & ~isr_pref[i];
  end

  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    for (int i = N_IR - 1; i >= 0; i--) begin
      if (cand[i]) begin
        win_vld_o = 1'b1;
        win_idx_o = IDX_W'(i);
      end
    end
  end

  assert_win_unmasked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld_o |-> ir_i[win_idx_o] && !imr_i[win_idx_o]);
  assert_win_not_blocked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld_o |-> (isr_i & ~({N_IR{1'b1}} << win_idx_o)) == '0 && !isr_i[win_idx_o]);
  assert_win_present_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ir_i & ~imr_i) != '0 && isr_i == '0) |-> win_vld_o);
endmodule

// File: rtl/pic_service.sv
module pic_service #(
  parameter int N_IR   = 8,
  parameter int DATA_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          is_master_i,
  input  logic                          inta_i,
  input  logic [N_IR-1:0]               cfg_i,
  input  logic [DATA_W-$clog2(N_IR)-1:0] base_i,
  input  logic                          win_vld_i,
  input  logic [$clog2(N_IR)-1:0]       win_idx_i,
  input  logic [$clog2(N_IR)-1:0]       cas_i,
  input  logic                          eoi_any_i,
  input  logic                          eoi_lvl_i,
  input  logic [$clog2(N_IR)-1:0]       eoi_idx_i,
  output logic [N_IR-1:0]               isr_o,
  output logic                          vec_vld_o,
  output logic [DATA_W-1:0]             vec_o,
  output logic [$clog2(N_IR)-1:0]       cas_o,
  output logic                          cas_oe_o
);
  localparam int IDX_W = $clog2(N_IR);

  logic            cascaded;
  logic            slave_sel;
  logic            take;
  logic            drive;
  logic [N_IR-1:0] isr_nxt;

  assign cascaded  = is_master_i && cfg_i[win_idx_i];
  assign slave_sel = !is_master_i && (cas_i == cfg_i[IDX_W-1:0]);
  assign take      = inta_i && win_vld_i && (is_master_i || slave_sel);
  assign drive     = take && !cascaded;
  assign cas_o     = win_idx_i;
  assign cas_oe_o  = inta_i && win_vld_i && cascaded;

  always_comb begin
    isr_nxt = isr_o;
    if (eoi_any_i) isr_nxt = isr_o & (isr_o - 1'b1);  // drop lowest set bit
    if (eoi_lvl_i) isr_nxt[eoi_idx_i] = 1'b0;
    if (take)      isr_nxt[win_idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_o     <= '0;
      vec_vld_o <= 1'b0;
      vec_o     <= '0;
    end else begin
      isr_o     <= isr_nxt;
      vec_vld_o <= drive;
      if (drive) vec_o <= {base_i, win_idx_i};
    end
  end

  assert_ack_sets_isr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !eoi_any_i && !eoi_lvl_i) |=> isr_o[$past(win_idx_i)]);
  assert_no_vec_cascaded_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && win_vld_i && cascaded) |=> !vec_vld_o);
  assert_slave_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_master_i && inta_i && cas_i != cfg_i[IDX_W-1:0] && !eoi_any_i && !eoi_lvl_i)
      |=> !vec_vld_o && $stable(isr_o));
  assert_eoi_lvl_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_lvl_i && !take) |=> !isr_o[$past(eoi_idx_i)]);
  assert_eoi_any_shrinks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_any_i && !take && isr_o != '0) |=> $countones(isr_o) == $countones($past(isr_o)) - 1);
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade #(
  parameter int N_IR   = 8,
  parameter int DATA_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sp_i,
  input  logic                    cs_i,
  input  logic                    rd_i,
  input  logic                    wr_i,
  input  logic                    a0_i,
  input  logic [DATA_W-1:0]       data_i,
  output logic [DATA_W-1:0]       data_o,
  output logic                    data_oe_o,
  input  logic [N_IR-1:0]         ir_i,
  output logic                    int_o,
  input  logic                    inta_i,
  input  logic [$clog2(N_IR)-1:0] cas_i,
  output logic [$clog2(N_IR)-1:0] cas_o,
  output logic                    cas_oe_o
);
  localparam int IDX_W  = $clog2(N_IR);
  localparam int BASE_W = DATA_W - IDX_W;

  logic [N_IR-1:0]   imr, cfg, isr;
  logic [BASE_W-1:0] base;
  logic              eoi_any, eoi_lvl;
  logic [IDX_W-1:0]  eoi_idx;
  logic              win_vld;
  logic [IDX_W-1:0]  win_idx;
  logic              vec_vld;
  logic [DATA_W-1:0] vec;
  logic [DATA_W-1:0] rd_data;

  pic_regs #(.N_IR(N_IR), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cs_i && wr_i),
    .a0_i      (a0_i),
    .wdata_i   (data_i),
    .imr_o     (imr),
    .base_o    (base),
    .cfg_o     (cfg),
    .eoi_any_o (eoi_any),
    .eoi_lvl_o (eoi_lvl),
    .eoi_idx_o (eoi_idx)
  );

  pic_prio #(.N_IR(N_IR)) u_prio (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ir_i      (ir_i),
    .imr_i     (imr),
    .isr_i     (isr),
    .win_vld_o (win_vld),
    .win_idx_o (win_idx)
  );

  pic_service #(.N_IR(N_IR), .DATA_W(DATA_W)) u_svc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .is_master_i (sp_i),
    .inta_i      (inta_i),
    .cfg_i       (cfg),
    .base_i      (base),
    .win_vld_i   (win_vld),
    .win_idx_i   (win_idx),
    .cas_i       (cas_i),
    .eoi_any_i   (eoi_any),
    .eoi_lvl_i   (eoi_lvl),
    .eoi_idx_i   (eoi_idx),
    .isr_o       (isr),
    .vec_vld_o   (vec_vld),
    .vec_o       (vec),
    .cas_o       (cas_o),
    .cas_oe_o    (cas_oe_o)
  );

  assign int_o     = win_vld;
  assign rd_data   = a0_i ? DATA_W'(imr) : DATA_W'(isr);
  assign data_o    = vec_vld ? vec : rd_data;
  assign data_oe_o = vec_vld || (cs_i && rd_i);

  assert_cas_only_master_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_oe_o |-> sp_i && inta_i);
  assert_vec_one_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_vld && !inta_i) |=> !vec_vld);
endmodule

// File: tb/pic_cascade_tb.sv
`timescale 1ns/1ps
module pic_cascade_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       m_cs = 0, s_cs = 0, rd = 0, wr = 0, a0 = 0, inta = 0;
  logic [7:0] wdata = '0, m_irx = '0, s_ir = '0, m_ir;
  logic [7:0] m_do, s_do;
  logic       m_oe, s_oe, m_int, s_int, m_cas_oe, s_cas_oe;
  logic [2:0] m_cas, s_cas;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  assign m_ir = {m_irx[7:4], s_int, m_irx[2:0]};

  pic_cascade u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sp_i(1'b1), .cs_i(m_cs), .rd_i(rd), .wr_i(wr),
    .a0_i(a0), .data_i(wdata), .data_o(m_do), .data_oe_o(m_oe), .ir_i(m_ir),
    .int_o(m_int), .inta_i(inta), .cas_i(3'd0), .cas_o(m_cas), .cas_oe_o(m_cas_oe));

  pic_cascade u_slv (
    .clk_i(clk), .rst_ni(rst_n), .sp_i(1'b0), .cs_i(s_cs), .rd_i(rd), .wr_i(wr),
    .a0_i(a0), .data_i(wdata), .data_o(s_do), .data_oe_o(s_oe), .ir_i(s_ir),
    .int_o(s_int), .inta_i(inta), .cas_i(m_cas), .cas_o(s_cas), .cas_oe_o(s_cas_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input bit slv, input bit sel, input logic [7:0] d, input bit csv = 1);
    @(negedge clk);
    if (slv) s_cs = csv; else m_cs = csv;
    wr = 1; a0 = sel; wdata = d;
    @(negedge clk);
    m_cs = 0; s_cs = 0; wr = 0;
  endtask

  task automatic rd_reg(input bit slv, input bit sel, output logic [7:0] d, output logic oe);
    @(negedge clk);
    if (slv) s_cs = 1; else m_cs = 1;
    rd = 1; a0 = sel;
    #1;
    d  = slv ? s_do : m_do;
    oe = slv ? s_oe : m_oe;
    @(negedge clk);
    m_cs = 0; s_cs = 0; rd = 0;
  endtask

  // ack: returns cas values during pulse and data bus of both in the next cycle
  logic       k_cas_oe, k_m_oe, k_s_oe;
  logic [2:0] k_cas;
  logic [7:0] k_m_do, k_s_do;
  task automatic ack();
    @(negedge clk);
    inta = 1;
    #1;
    k_cas_oe = m_cas_oe; k_cas = m_cas;
    @(negedge clk);
    inta = 0;
    #1;
    k_m_oe = m_oe; k_m_do = m_do; k_s_oe = s_oe; k_s_do = s_do;
  endtask

  function automatic int exp_win(input logic [7:0] req, input logic [7:0] msk, input logic [7:0] isr);
    for (int i = 0; i < 8; i++) begin
      if (isr[i]) return 8;
      if (req[i] && !msk[i]) return i;
    end
    return 8;
  endfunction

  logic [7:0] rv;
  logic       roe;

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 int", m_int, 0);
    chk("R1 oe", m_oe, 0);
    chk("R1 cas_oe", m_cas_oe, 0);
    rd_reg(0, 1, rv, roe); chk("R1 imr", rv, 8'hFF);
    rd_reg(0, 0, rv, roe); chk("R1 isr", rv, 8'h00);

    // program: master base 0x20, input 3 cascaded; slave base 0x40, id 3
    wr_reg(0, 0, 8'h84);
    wr_reg(0, 1, 8'h00);
    wr_reg(0, 0, 8'hC0);
    wr_reg(0, 1, 8'h08);
    wr_reg(1, 0, 8'h88);
    wr_reg(1, 1, 8'h00);
    wr_reg(1, 0, 8'hC0);
    wr_reg(1, 1, 8'h03);
    rd_reg(0, 1, rv, roe);
    chk("R12 imr read", rv, 8'h00); chk("R12 oe", roe, 1);
    chk("R9 cfg write left mask", rv, 8'h00);
    rd_reg(1, 1, rv, roe); chk("R9 slave mask", rv, 8'h00);
    // R13 write without cs
    wr_reg(0, 1, 8'hFF, 0);
    rd_reg(0, 1, rv, roe); chk("R13 mask unchanged", rv, 8'h00);

    // random priority / mask on master (input 3 reserved for slave)
    for (int it = 0; it < 60; it++) begin
      logic [7:0] req, msk;
      int w;
      req = 8'($urandom) & 8'hF7;
      msk = 8'($urandom);
      wr_reg(0, 1, msk);
      @(negedge clk); m_irx = req;
      #1;
      w = exp_win(req, msk, 8'h00);
      chk("R2/R3 int", m_int, (w < 8));
      if (w < 8) begin
        ack();
        chk("R5 vec oe", k_m_oe, 1);
        chk("R5 vector", k_m_do, {5'd4, 3'(w)});
        m_irx = '0;
        rd_reg(0, 0, rv, roe); chk("R5 isr", rv, 8'(1) << w);
        chk("R5 oe drop", roe, 1);
        wr_reg(0, 0, 8'h00);
        rd_reg(0, 0, rv, roe); chk("R6 eoi", rv, 8'h00);
      end
      m_irx = '0;
    end
    wr_reg(0, 1, 8'h00);

    // R4 nesting
    @(negedge clk); m_irx = 8'h20;
    ack();
    chk("R5 vec5", k_m_do, 8'h25);
    #1 chk("R4 same level blocked", m_int, 0);
    @(negedge clk); m_irx = 8'h60; #1;
    chk("R4 lower blocked", m_int, 0);
    @(negedge clk); m_irx = 8'h64; #1;
    chk("R4 higher passes", m_int, 1);
    ack();
    chk("R4 nested vector", k_m_do, 8'h22);
    m_irx = '0;
    rd_reg(0, 0, rv, roe); chk("R4 isr nest", rv, 8'h24);
    wr_reg(0, 0, 8'h00);
    rd_reg(0, 0, rv, roe); chk("R6 lowest cleared", rv, 8'h20);
    wr_reg(0, 0, 8'h45);
    rd_reg(0, 0, rv, roe); chk("R7 specific eoi", rv, 8'h00);

    // R8 base change
    wr_reg(0, 0, 8'h9F);
    @(negedge clk); m_irx = 8'h01;
    ack();
    chk("R8 vector", k_m_do, 8'hF8);
    m_irx = '0;
    wr_reg(0, 0, 8'h00);
    wr_reg(0, 0, 8'h84);

    // R10/R11 cascaded acknowledge
    @(negedge clk); s_ir = 8'h40; #1;
    chk("R2 cascaded int", m_int, 1);
    ack();
    chk("R10 cas_oe", k_cas_oe, 1);
    chk("R10 cas code", k_cas, 3'd3);
    chk("R10 master quiet", k_m_oe, 0);
    chk("R11 slave oe", k_s_oe, 1);
    chk("R11 slave vector", k_s_do, 8'h46);
    s_ir = '0;
    rd_reg(0, 0, rv, roe); chk("R10 master isr", rv, 8'h08);
    rd_reg(1, 0, rv, roe); chk("R11 slave isr", rv, 8'h40);
    wr_reg(1, 0, 8'h00);
    wr_reg(0, 0, 8'h00);

    // R11 mismatch: master input 0 wins, slave also pending
    @(negedge clk); s_ir = 8'h02; m_irx = 8'h01;
    ack();
    chk("R10 no cas drive", k_cas_oe, 0);
    chk("R11 slave silent", k_s_oe, 0);
    chk("R5 master vector", k_m_do, 8'h20);
    s_ir = '0; m_irx = '0;
    rd_reg(1, 0, rv, roe); chk("R11 slave isr kept", rv, 8'h00);
    wr_reg(0, 0, 8'h00);
    rd_reg(0, 0, rv, roe); chk("R6 master clear", rv, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule